// File: doc/BRIEF.md
# Serial Flash Chip-Select and Clock Sequencer

This block frames transactions for a serial flash master. It derives the serial clock from the reference clock and drives a set of active-low chip selects around each transaction. A request names a target with a select code and gives a length in bits. The sequencer then lowers the chosen chip select and waits a lead-in time. It runs the serial clock for the word, holds the select for a trailing time and releases it. A one-cycle done pulse marks the release. Shifting data, opcodes and flash commands belong to the block around it.

Spacing between transactions is enforced in reference clocks. A repeat access to the same device needs one quiet gap. An access that moves to another device needs a longer gap with its own delay setting. The select code reaches the pins in one of two ways. The lowest-numbered zero bit can win as a priority pick, or the code can go to the pins unchanged so an external decoder can use it. There is one pending-request slot. A request that comes in while the slot is full is dropped. A request that comes in while a transaction is running waits in the slot. Clearing the enable lets the running word finish, and then the output drivers turn off.

Top module: `spi_cs_seq`

## Requirements
- R1: With divisor code n on `div_i`, every level of the serial clock inside a word lasts H = n+1 reference clocks, so the serial clock runs at the reference rate divided by 2(n+1).
- R2: Outside a transaction `sclk_o` sits at the `cpol_i` level. A word of b bits makes 2b clock edges, and a `req_bits_i` of 0 is treated as 1. With `cpha_i`=1 the word starts with an extra idle half period of H clocks before its first edge.
- R3: The chip select goes low H + S reference clocks before the first serial clock edge (plus H more when `cpha_i`=1), where S is `sot_dly_i`.
- R4: The chip select goes high E reference clocks after the last edge that returns the clock to idle, where E is `eot_dly_i`. With E=0 it rises in the same cycle as that edge.
- R5: When a held request targets the same chip-select pattern as the previous transaction, the selects stay all high for exactly 2H + 1 + G reference clocks between the two, where G is `gap_dly_i`.
- R6: When a held request targets a different chip-select pattern, the all-high gap is exactly 2H + 3 + W reference clocks, where W is `swap_dly_i`.
- R7: With `cs_decode_i`=0, the lowest zero bit i of the select code drives `cs_n_o[i]` low and all other outputs stay high. A code of all ones keeps every output high for the whole transaction.
- R8: With `cs_decode_i`=1, `cs_n_o` equals the select code for the whole transaction.
- R9: `done_o` is high for exactly one reference clock, in the first cycle after a transaction in which `busy_o` is low. It is never high at any other time.
- R10: While `enable_i` is low, no new transaction starts and a running one completes unchanged. `oe_o` stays high while `busy_o` is high and is low when the block is idle and disabled. A held request starts after the enable returns.
- R11: A transaction uses the divisor, phase, polarity and delay settings that were present when it started. Changing the settings while it is busy affects only later transactions and the gap in front of them.
- R12: During and right after reset, `cs_n_o` is all ones, `sclk_o` equals `cpol_i`, and `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows new transactions to start; its release lets the current word finish |
| div_i | input | DIV_W | Divisor code n; half period is n+1 reference clocks |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Adds a leading idle half period to each word |
| sot_dly_i | input | DLY_W | Extra lead time before the first clock edge |
| eot_dly_i | input | DLY_W | Extra hold time after the last clock edge |
| gap_dly_i | input | DLY_W | Extra quiet time between accesses to the same device |
| swap_dly_i | input | DLY_W | Extra quiet time when switching devices |
| cs_decode_i | input | 1 | 1: select code passes straight to the pins; 0: priority pick |
| req_i | input | 1 | One-cycle transaction request strobe |
| req_sel_i | input | CS_W | Target select code |
| req_bits_i | input | BITS_W | Word length in bits |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | CS_W | Active-low chip selects |
| done_o | output | 1 | One-cycle pulse after chip-select release |
| busy_o | output | 1 | High while a chip select is framed |
| oe_o | output | 1 | Output-driver enable for the serial pins |

## Verification
The bench targets the exact lengths of the quiet gaps. It runs pairs that resolve to the same pattern from different codes, and chains that change device each time. A design that compares raw codes rather than resolved patterns, or that mixes up the two delay settings, misses the gap by a few cycles. Lead and trail times are measured at zero and non-zero delays under both phase settings. An off-by-one in the half-period counter, or a lost idle half period, shows up in the lead count or the edge spacing. The settings are changed in the middle of a transaction and the enable is dropped during one, to catch a design that reads live settings or that cuts a word short. The all-ones code in both mapping modes, and a word length of zero, are also exercised.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } seq_st_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_cs_seq_map.sv
module spi_cs_seq_map #(
  parameter int CS_W = 4
) (
  input  logic [CS_W-1:0] sel_i,
  input  logic            decode_i,
  output logic [CS_W-1:0] cs_n_o
);
  logic [CS_W-1:0] pri_n;

  // bit i wins when it is zero and every lower bit is one
  for (genvar i = 0; i < CS_W; i++) begin : g_pri
    localparam logic [CS_W-1:0] LOW = (CS_W'(1) << i) - CS_W'(1);
    assign pri_n[i] = sel_i[i] | ~(&(sel_i | ~LOW));
  end

  assign cs_n_o = decode_i ? sel_i : pri_n;
endmodule

// File: rtl/spi_cs_seq_slot.sv
module spi_cs_seq_slot #(
  parameter int CS_W   = 4,
  parameter int BITS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CS_W-1:0]   sel_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [CS_W-1:0]   sel_o,
  output logic [BITS_W-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sel_o   <= '1;
      bits_o  <= '0;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end else if (req_i && !valid_o) begin
      valid_o <= 1'b1;
      sel_o   <= sel_i;
      bits_o  <= bits_i;
    end
  end
endmodule

// File: rtl/spi_cs_seq_gap.sv
module spi_cs_seq_gap #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             same_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] gap_dly_i,
  input  logic [DLY_W-1:0] swap_dly_i,
  output logic             ok_o
);
  localparam int QW = spi_cs_seq_pkg::max_int(DIV_W + 1, DLY_W) + 2;

  logic [QW-1:0] quiet_q;
  logic [QW-1:0] need;

  // 2H+1+G for the same device, 2H+3+W for a new one, with H = div+1
  always_comb begin
    need = (QW'(div_i) << 1) +
           (same_i ? QW'(gap_dly_i) + QW'(3) : QW'(swap_dly_i) + QW'(5));
  end

  // counts the high cycles so far, including the current one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             quiet_q <= '1;
    else if (busy_i)         quiet_q <= QW'(1);
    else if (quiet_q != '1)  quiet_q <= quiet_q + QW'(1);
  end

  assign ok_o = (quiet_q >= need);
endmodule

// File: rtl/spi_cs_seq_fsm.sv
module spi_cs_seq_fsm
  import spi_cs_seq_pkg::*;
#(
  parameter int CS_W   = 4,
  parameter int BITS_W = 6,
  parameter int DIV_W  = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CS_W-1:0]   pat_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DLY_W-1:0]  sot_i,
  input  logic [DLY_W-1:0]  eot_i,
  input  logic              pol_i,
  input  logic              pha_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic [CS_W-1:0]   cs_n_o,
  output logic [CS_W-1:0]   last_pat_o,
  output logic              done_o
);
  localparam int CW = max_int(DIV_W, DLY_W) + 1;
  localparam int PW = BITS_W + 1;

  seq_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic [PW-1:0]     ph_q, last_ph_q, last_ph_d, bits_ext;
  logic [DIV_W-1:0]  half_q;
  logic [DLY_W-1:0]  eot_q;
  logic              pha_q, pol_q, done_q;
  logic [CS_W-1:0]   pat_q;

  always_comb begin
    bits_ext  = (bits_i == '0) ? PW'(1) : PW'(bits_i);
    last_ph_d = (bits_ext << 1) - PW'(2) + PW'(pha_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      ph_q      <= '0;
      last_ph_q <= '0;
      half_q    <= '0;
      eot_q     <= '0;
      pha_q     <= 1'b0;
      pol_q     <= 1'b0;
      pat_q     <= '1;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q      <= ST_LEAD;
            cnt_q     <= CW'(div_i) + CW'(sot_i);
            half_q    <= div_i;
            eot_q     <= eot_i;
            pha_q     <= pha_i;
            pol_q     <= pol_i;
            pat_q     <= pat_i;
            last_ph_q <= last_ph_d;
          end
        end
        ST_LEAD: begin
          if (cnt_q == '0) begin
            st_q  <= ST_SHIFT;
            cnt_q <= CW'(half_q);
            ph_q  <= '0;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_SHIFT: begin
          if (cnt_q == '0) begin
            if (ph_q == last_ph_q) begin
              if (eot_q == '0) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                st_q  <= ST_TAIL;
                cnt_q <= CW'(eot_q) - CW'(1);
              end
            end else begin
              ph_q  <= ph_q + PW'(1);
              cnt_q <= CW'(half_q);
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_TAIL: begin
          if (cnt_q == '0) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // active half periods: even phases with pha=0, odd phases with pha=1
  always_comb begin
    if (st_q == ST_IDLE)                        sclk_o = pol_i;
    else if (st_q == ST_SHIFT && ph_q[0] == pha_q) sclk_o = ~pol_q;
    else                                        sclk_o = pol_q;
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign cs_n_o     = busy_o ? pat_q : '1;
  assign last_pat_o = pat_q;
  assign done_o     = done_q;
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq #(
  parameter int CS_W   = 4,
  parameter int BITS_W = 6,
  parameter int DIV_W  = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DLY_W-1:0]  sot_dly_i,
  input  logic [DLY_W-1:0]  eot_dly_i,
  input  logic [DLY_W-1:0]  gap_dly_i,
  input  logic [DLY_W-1:0]  swap_dly_i,
  input  logic              cs_decode_i,
  input  logic              req_i,
  input  logic [CS_W-1:0]   req_sel_i,
  input  logic [BITS_W-1:0] req_bits_i,
  output logic              sclk_o,
  output logic [CS_W-1:0]   cs_n_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              oe_o
);
  logic              pend_v;
  logic [CS_W-1:0]   pend_sel;
  logic [BITS_W-1:0] pend_bits;
  logic [CS_W-1:0]   cand_pat, last_pat;
  logic              gap_ok, start, busy;

  spi_cs_seq_slot #(.CS_W(CS_W), .BITS_W(BITS_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .sel_i   (req_sel_i),
    .bits_i  (req_bits_i),
    .take_i  (start),
    .valid_o (pend_v),
    .sel_o   (pend_sel),
    .bits_o  (pend_bits)
  );

  spi_cs_seq_map #(.CS_W(CS_W)) u_map (
    .sel_i    (pend_sel),
    .decode_i (cs_decode_i),
    .cs_n_o   (cand_pat)
  );

  spi_cs_seq_gap #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .same_i     (cand_pat == last_pat),
    .div_i      (div_i),
    .gap_dly_i  (gap_dly_i),
    .swap_dly_i (swap_dly_i),
    .ok_o       (gap_ok)
  );

  assign start = !busy && pend_v && enable_i && gap_ok;

  spi_cs_seq_fsm #(
    .CS_W(CS_W), .BITS_W(BITS_W), .DIV_W(DIV_W), .DLY_W(DLY_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .pat_i      (cand_pat),
    .bits_i     (pend_bits),
    .div_i      (div_i),
    .sot_i      (sot_dly_i),
    .eot_i      (eot_dly_i),
    .pol_i      (cpol_i),
    .pha_i      (cpha_i),
    .busy_o     (busy),
    .sclk_o     (sclk_o),
    .cs_n_o     (cs_n_o),
    .last_pat_o (last_pat),
    .done_o     (done_o)
  );

  assign busy_o = busy;
  assign oe_o   = enable_i | busy;
endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o
);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_at_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_start_enabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(enable_i));

  p_no_edge_at_select_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (sclk_o == $past(sclk_o)));

  p_gap_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> !busy_o);
endmodule

bind spi_cs_seq spi_cs_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .sclk_o   (sclk_o)
);

// File: tb/spi_cs_seq_tb.sv
module spi_cs_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] div = 4'd1;
  logic       cpol = 1'b0, cpha = 1'b0, dec = 1'b0, req = 1'b0;
  logic [7:0] sot = '0, eot = '0, gap = '0, swap = '0;
  logic [3:0] rsel = '1;
  logic [5:0] rbits = '0;
  logic       sclk, done, busy, oe;
  logic [3:0] cs_n;

  always #2.5 clk = ~clk;

  spi_cs_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .div_i(div),
    .cpol_i(cpol), .cpha_i(cpha), .sot_dly_i(sot), .eot_dly_i(eot),
    .gap_dly_i(gap), .swap_dly_i(swap), .cs_decode_i(dec), .req_i(req),
    .req_sel_i(rsel), .req_bits_i(rbits), .sclk_o(sclk), .cs_n_o(cs_n),
    .done_o(done), .busy_o(busy), .oe_o(oe)
  );

  typedef struct {
    int pat; int lead; int edges; int half; int tail; int gap;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int model_pat(input logic [3:0] s, input logic d);
    if (d) return int'(s);
    for (int i = 0; i < 4; i++)
      if (!s[i]) return int'(4'hF & ~(4'h1 << i));
    return 15;
  endfunction

  function automatic int g_same();
    return 2 * (int'(div) + 1) + 1 + int'(gap);
  endfunction

  function automatic int g_diff();
    return 2 * (int'(div) + 1) + 3 + int'(swap);
  endfunction

  task automatic cfg(input int d, input int s, input int e, input int g, input int w,
                     input bit pol, input bit pha, input bit dm);
    div = 4'(d); sot = 8'(s); eot = 8'(e); gap = 8'(g); swap = 8'(w);
    cpol = pol; cpha = pha; dec = dm;
  endtask

  // driver: pushes the expected framing, then strobes the request
  task automatic send(input logic [3:0] s, input int b, input int gexp);
    exp_t it;
    int h;
    h = int'(div) + 1;
    it.pat   = model_pat(s, dec);
    it.lead  = h + int'(sot) + (cpha ? h : 0);
    it.edges = 2 * ((b == 0) ? 1 : b);
    it.half  = h;
    it.tail  = int'(eot);
    it.gap   = gexp;
    q.push_back(it);
    @(posedge clk); #1;
    req = 1'b1; rsel = s; rbits = 6'(b);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wait_start();
    @(posedge busy); #1;
  endtask

  task automatic drain();
    while (q.size() != 0 || busy) @(negedge clk);
    repeat (6) @(negedge clk);
    #1;
  endtask

  // monitor
  bit   prev_busy = 1'b0;
  logic prev_sclk = 1'b0;
  int   now = 0, idle_run = 100000, st_cyc = 0, m_gap = 0, m_pat = 0;
  int   edge_n = 0, first_e = -1, last_e = 0, half_bad = 0, cur_half = 0;
  bit   half_err = 1'b0, pat_err = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_busy = 1'b0;
      prev_sclk = sclk;
    end else begin
      exp_t e;
      now++;
      if (busy && !prev_busy) begin
        st_cyc = now; m_gap = idle_run; m_pat = int'(cs_n);
        edge_n = 0; first_e = -1; last_e = now;
        half_err = 1'b0; half_bad = 0; pat_err = 1'b0;
        cur_half = (q.size() > 0) ? q[0].half : 0;
      end
      if (busy && int'(cs_n) != m_pat) pat_err = 1'b1;
      if ((busy || prev_busy) && sclk !== prev_sclk) begin
        if (edge_n == 0) first_e = now;
        else if (now - last_e != cur_half && !half_err) begin
          half_err = 1'b1;
          half_bad = now - last_e;
        end
        last_e = now;
        edge_n++;
      end
      if (done && !(!busy && prev_busy)) chk("R9 stray done", 1, 0);
      if (!busy && prev_busy) begin
        if (q.size() == 0) begin
          chk("R10 unexpected transaction", 1, 0);
        end else begin
          e = q.pop_front();
          chk("R7 R8 chip-select pattern", m_pat, e.pat);
          chk("R7 R8 pattern stable", int'(pat_err), 0);
          chk("R3 R2 lead cycles", first_e - st_cyc, e.lead);
          chk("R2 edge count", edge_n, e.edges);
          chk("R1 half period", half_err ? half_bad : e.half, e.half);
          chk("R4 tail cycles", now - last_e, e.tail);
          if (e.gap >= 0) chk("R5 R6 quiet gap", m_gap, e.gap);
        end
        chk("R9 done at release", int'(done), 1);
        idle_run = 1;
      end else if (!busy) begin
        idle_run++;
      end
      prev_busy = busy;
      prev_sclk = sclk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("R12 watchdog expired", 0, 1);
    report();
  end

  initial begin
    int ok;
    repeat (3) @(negedge clk);
    chk("R12 reset cs_n", int'(cs_n), 15);
    chk("R12 reset sclk", int'(sclk), 0);
    chk("R12 reset done", int'(done), 0);
    chk("R12 reset busy", int'(busy), 0);
    chk("R10 oe while disabled", int'(oe), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after reset cs_n", int'(cs_n), 15);
    chk("R12 after reset busy", int'(busy), 0);
    @(posedge clk); #1;
    enable = 1'b1;

    // same device from different codes, then device switches
    cfg(2, 4, 2, 3, 7, 1'b0, 1'b0, 1'b0);
    send(4'b0110, 2, -1);
    wait_start();
    send(4'b1010, 1, g_same());          // R5: same resolved pattern
    drain();
    send(4'b1101, 3, -1);
    wait_start();
    send(4'b1011, 2, g_diff());          // R6
    wait_start();
    send(4'b0111, 1, g_diff());          // R6, R7
    drain();

    // raw decode and all-ones code, zero length
    cfg(2, 0, 1, 0, 2, 1'b0, 1'b0, 1'b1);
    send(4'b1001, 2, -1);                // R8
    wait_start();
    send(4'b0110, 1, g_diff());
    drain();
    cfg(1, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    send(4'b1111, 0, -1);                // R7 all ones, R2 zero length
    drain();

    // polarity and phase
    cfg(0, 0, 0, 0, 0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R2 idle level high", int'(sclk), 1);
    send(4'b0000, 4, -1);
    wait_start();
    send(4'b1100, 2, g_same());
    drain();
    cfg(3, 0, 1, 0, 0, 1'b0, 1'b1, 1'b0);
    send(4'b0111, 1, -1);
    drain();

    // settings changed mid-transaction
    cfg(1, 1, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    send(4'b0100, 3, -1);
    wait_start();
    cfg(3, 0, 3, 0, 0, 1'b0, 1'b0, 1'b0);
    send(4'b0100, 2, g_same());          // R11
    drain();

    // disable during a transaction
    cfg(1, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    send(4'b1110, 4, -1);
    wait_start();
    enable = 1'b0;
    send(4'b1101, 1, -1);
    @(negedge clk);
    chk("R10 oe kept while busy", int'(oe), 1);
    while (busy) @(negedge clk);
    ok = 1;
    repeat (40) begin
      @(negedge clk);
      if (busy || oe) ok = 0;
    end
    chk("R10 held while disabled, drivers off", ok, 1);
    @(posedge clk); #1;
    enable = 1'b1;
    drain();
    chk("R10 queue empty at end", q.size(), 0);
    report();
  end
endmodule